// File: doc/BRIEF.md
# Event-Triggered Parallel Data Capture Controller

This block takes a snapshot of an external parallel data bus when a selected capture event arrives. The snapshot is taken either on the same clock as the event or a programmable 1 to 15 clocks later. A single 16-bit configuration word sets several things: which of four event inputs triggers a sample, how wide the sampled word is, which of two pin groups drives the upper half, and the delay. It also chooses how capture becomes live. Either the enable bit alone starts it, or the enable bit plus a pulse from one of several hardware sources. A counter-underflow input can be chosen to stop it again.

The captured word and a one-cycle valid strobe are the only data outputs. The configuration word can be changed only while the module-run input is high. It is forced to zero whenever that input is low. Event detectors, counters and any downstream transfer of the captured data are outside the block. Their pulses arrive as plain inputs.

Top module: `evcap_ctrl`

## Requirements
- R1: After reset the configuration readback is 0x0000. While `mod_run` is low, the register is cleared on every clock and writes are ignored.
- R2: A write whose bit 15 is 1 leaves the register unchanged. Bit 15 of the readback is always 0.
- R3: A write with bit 15 clear and `mod_run` high is visible on `cfg_rdata` after the write edge. Field layout: [14] enable, [13:12] stop source, [11:9] arm source, [8] pin group, [7:6] event select, [5:4] width, [3:0] delay.
- R4: When the arm source is 0xx, capture goes live on the clock after the enable bit changes from 0 to 1.
- R5: Arm source 100, 101 and 110 select `arm_evt[0]`, `[1]` and `[2]`; 111 selects `arm_uf`. With enable set, a pulse on the selected input makes capture live from the next cycle. Before that pulse, capture events are not sampled.
- R6: Stop source 01, 10 and 11 select `stop_uf[0]`, `[1]` and `[2]`, and 00 selects none. A pulse on the selected input ends live capture and wins over a same-cycle arm. Clearing the enable bit also ends live capture. Pulses on inputs that are not selected have no effect.
- R7: Width 00 captures `din_lo[7:0]` zero-extended, 01 captures `din_lo` zero-extended, and 10 captures {upper group, `din_lo`}.
- R8: With width code 11, an event starts no capture and `cap_valid` stays low. `cap_data` keeps its previous value.
- R9: Only `cap_evt[event select]` triggers a sample. The other event inputs are ignored.
- R10: If an accepted event arrives at edge e with delay d, the data is sampled at edge e+d. `cap_valid` is high for exactly the one cycle after that edge, with the sample on `cap_data`.
- R11: An event that arrives while a delayed sample is pending is dropped. It produces no later sample.
- R12: In 32-bit mode, pin group 0 places `din_grp_a` in the upper half and pin group 1 places `din_grp_b` there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| mod_run | input | 1 | Module run control; low clears and locks the configuration |
| cfg_wr | input | 1 | Aligned 16-bit configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| arm_evt | input | 3 | Arming event detector pulses |
| arm_uf | input | 1 | Arming counter underflow pulse |
| stop_uf | input | 3 | Stopping counter underflow pulses |
| cap_evt | input | 4 | Capture event detector pulses |
| din_lo | input | HW | Lower half of the data bus |
| din_grp_a | input | HW | Upper half, pin group 0 |
| din_grp_b | input | HW | Upper half, pin group 1 |
| cap_data | output | 2*HW | Captured word |
| cap_valid | output | 1 | One-cycle capture strobe |

## Verification
Several properties are checked on every cycle by the assertions: the register is cleared while the module is halted, protected writes leave it unchanged, live capture ends on enable-low or on a stop pulse, the inhibited width never yields a strobe, and a pending countdown that reaches one always produces a strobe. Other behaviour can only be shown by the bench's scenarios. This covers arm-source and stop-source decoding, width and pin-group assembly, the exact sampling edge under a non-zero delay, and dropping a second event during the countdown. The bench checks these against a behavioural model compared on every clock and against hand-computed expected words.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  localparam int REG_W = 16;
  localparam int DLY_W = 4;

  typedef enum logic [1:0] {WID_8 = 2'd0, WID_16 = 2'd1, WID_32 = 2'd2, WID_BAD = 2'd3} wid_e;

  typedef struct packed {
    logic             wprot;
    logic             en;
    logic [1:0]       stop_sel;
    logic [2:0]       arm_sel;
    logic             grp;
    logic [1:0]       evt_sel;
    wid_e             wid;
    logic [DLY_W-1:0] dly;
  } cfg_t;

  function automatic cfg_t cfg_unpack(input logic [REG_W-1:0] w);
    cfg_t c;
    c = cfg_t'(w);
    c.wprot = 1'b0;
    return c;
  endfunction

  function automatic logic arm_pick(input logic [2:0] sel, input logic [2:0] ev, input logic uf);
    logic r;
    case (sel)
      3'b100:  r = ev[0];
      3'b101:  r = ev[1];
      3'b110:  r = ev[2];
      3'b111:  r = uf;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic stop_pick(input logic [1:0] sel, input logic [2:0] uf);
    logic r;
    case (sel)
      2'b01:   r = uf[0];
      2'b10:   r = uf[1];
      2'b11:   r = uf[2];
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/evcap_regs.sv
module evcap_regs
  import evcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_run,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output cfg_t             cfg_q,
  output logic             wr_take
);
  assign wr_take = mod_run && cfg_wr && !cfg_wdata[REG_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_q <= '0;
    else if (!mod_run) cfg_q <= '0;
    else if (wr_take)  cfg_q <= cfg_unpack(cfg_wdata);
  end

  assert_clear_on_halt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_run |=> (cfg_q == '0));

  assert_wprot_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_run && cfg_wr && cfg_wdata[REG_W-1]) |=> (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/evcap_arm.sv
module evcap_arm
  import evcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cfg_t       cfg,
  input  logic [2:0] arm_evt,
  input  logic       arm_uf,
  input  logic [2:0] stop_uf,
  output logic       run,
  output logic       arm_hit,
  output logic       stop_hit
);
  logic en_q;
  logic trig;

  assign arm_hit  = arm_pick(cfg.arm_sel, arm_evt, arm_uf);
  assign stop_hit = stop_pick(cfg.stop_sel, stop_uf);
  assign trig     = cfg.arm_sel[2] ? arm_hit : (cfg.en && !en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      run  <= 1'b0;
    end else begin
      en_q <= cfg.en;
      if (!cfg.en)       run <= 1'b0;
      else if (stop_hit) run <= 1'b0;
      else if (trig)     run <= 1'b1;
    end
  end

  assert_en_low_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> !run);

  assert_stop_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && stop_hit) |=> !run);
endmodule

// File: rtl/evcap_sampler.sv
module evcap_sampler
  import evcap_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cfg_t          cfg,
  input  logic          run,
  input  logic [3:0]    cap_evt,
  input  logic [HW-1:0] din_lo,
  input  logic [HW-1:0] din_grp_a,
  input  logic [HW-1:0] din_grp_b,
  output logic [2*HW-1:0] cap_data,
  output logic          cap_valid,
  output logic          evt_take,
  output logic          pending,
  output logic          sample_now
);
  localparam int QW = HW / 2;

  function automatic logic [2*HW-1:0] assemble(input wid_e w, input logic g,
      input logic [HW-1:0] lo, input logic [HW-1:0] a, input logic [HW-1:0] b);
    logic [2*HW-1:0] r;
    case (w)
      WID_8:   r = {{(2*HW-QW){1'b0}}, lo[QW-1:0]};
      WID_16:  r = {{HW{1'b0}}, lo};
      WID_32:  r = {(g ? b : a), lo};
      default: r = '0;
    endcase
    return r;
  endfunction

  logic [DLY_W-1:0] cnt;
  logic             evt_hit;

  assign evt_hit    = cap_evt[cfg.evt_sel];
  assign evt_take   = run && cfg.en && (cfg.wid != WID_BAD) && evt_hit && !pending;
  assign sample_now = cfg.en && ((pending && cnt == DLY_W'(1)) ||
                                 (evt_take && cfg.dly == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_data  <= '0;
      pending   <= 1'b0;
      cnt       <= '0;
    end else begin
      cap_valid <= sample_now;
      if (sample_now) cap_data <= assemble(cfg.wid, cfg.grp, din_lo, din_grp_a, din_grp_b);
      if (!cfg.en) begin
        pending <= 1'b0;
        cnt     <= '0;
      end else if (pending) begin
        if (cnt == DLY_W'(1)) pending <= 1'b0;
        cnt <= cnt - DLY_W'(1);
      end else if (evt_take && cfg.dly != '0) begin
        pending <= 1'b1;
        cnt     <= cfg.dly;
      end
    end
  end

  assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.wid == WID_BAD && !pending) |=> !cap_valid);

  assert_busy_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (cnt != '0));

  assert_due_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && cnt == DLY_W'(1) && cfg.en) |=> cap_valid);
endmodule

// File: rtl/evcap_ctrl.sv
module evcap_ctrl
  import evcap_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mod_run,
  input  logic            cfg_wr,
  input  logic [15:0]     cfg_wdata,
  output logic [15:0]     cfg_rdata,
  input  logic [2:0]      arm_evt,
  input  logic            arm_uf,
  input  logic [2:0]      stop_uf,
  input  logic [3:0]      cap_evt,
  input  logic [HW-1:0]   din_lo,
  input  logic [HW-1:0]   din_grp_a,
  input  logic [HW-1:0]   din_grp_b,
  output logic [2*HW-1:0] cap_data,
  output logic            cap_valid
);
  cfg_t cfg;
  logic wr_take, run, arm_hit, stop_hit, evt_take, pending, sample_now;

  evcap_regs u_regs (
    .clk(clk), .rst_n(rst_n), .mod_run(mod_run), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg), .wr_take(wr_take)
  );

  evcap_arm u_arm (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .arm_evt(arm_evt), .arm_uf(arm_uf),
    .stop_uf(stop_uf), .run(run), .arm_hit(arm_hit), .stop_hit(stop_hit)
  );

  evcap_sampler #(.HW(HW)) u_smp (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .run(run), .cap_evt(cap_evt),
    .din_lo(din_lo), .din_grp_a(din_grp_a), .din_grp_b(din_grp_b),
    .cap_data(cap_data), .cap_valid(cap_valid), .evt_take(evt_take),
    .pending(pending), .sample_now(sample_now)
  );

  assign cfg_rdata = cfg;

  assert_rdata_prot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[15] == 1'b0);
endmodule

// File: tb/test_evcap_ctrl.sv
`timescale 1ns/1ps
module test_evcap_ctrl;
  logic clk = 0, rst_n = 0, mod_run = 0, cfg_wr = 0, arm_uf = 0;
  logic [15:0] cfg_wdata = 0, din_lo = 0, din_grp_a = 0, din_grp_b = 0;
  logic [2:0] arm_evt = 0, stop_uf = 0;
  logic [3:0] cap_evt = 0;
  logic [15:0] cfg_rdata;
  logic [31:0] cap_data;
  logic cap_valid;
  int n_run = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evcap_ctrl i_evcap_ctrl (.*);

  // behavioural reference model
  int m_cfg, m_enq, m_run, m_pend, m_cnt, m_val;
  longint m_dat;
  int en, ac, sc, wd, es, gp, dl, ah, sh, tk, sm;

  function automatic longint pack(int w, int g, int lo, int a, int b);
    if (w == 0) return lo % 256;
    if (w == 1) return lo;
    if (w == 2) return (longint'(g ? b : a) * 65536) + lo;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_enq = 0; m_run = 0; m_pend = 0; m_cnt = 0; m_val = 0; m_dat = 0;
    end else begin
      en = (m_cfg / 16384) % 2; sc = (m_cfg / 4096) % 4; ac = (m_cfg / 512) % 8;
      gp = (m_cfg / 256) % 2; es = (m_cfg / 64) % 4; wd = (m_cfg / 16) % 4; dl = m_cfg % 16;
      ah = (ac >= 4) ? ((ac == 7) ? int'(arm_uf) : int'(arm_evt[ac-4])) : 0;
      sh = (sc == 0) ? 0 : int'(stop_uf[sc-1]);
      tk = (m_run && en && wd != 3 && cap_evt[es] && !m_pend) ? 1 : 0;
      sm = (en && ((m_pend && m_cnt == 1) || (tk && dl == 0))) ? 1 : 0;
      m_val = sm;
      if (sm) m_dat = pack(wd, gp, din_lo, din_grp_a, din_grp_b);
      if (!en) begin m_pend = 0; m_cnt = 0; end
      else if (m_pend) begin if (m_cnt == 1) m_pend = 0; m_cnt = m_cnt - 1; end
      else if (tk && dl != 0) begin m_pend = 1; m_cnt = dl; end
      if (!en) m_run = 0;
      else if (sh) m_run = 0;
      else if ((ac >= 4) ? ah : (en && !m_enq)) m_run = 1;
      m_enq = en;
      if (!mod_run) m_cfg = 0;
      else if (cfg_wr && !cfg_wdata[15]) m_cfg = cfg_wdata;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    n_run++;
    if (cfg_rdata != 16'(m_cfg) || cap_valid != 1'(m_val) || cap_data != 32'(m_dat)) begin
      n_bad++;
      $display("FAIL R10 model: rdata=%h/%h valid=%0d/%0d data=%h/%h", cfg_rdata, 16'(m_cfg),
               cap_valid, m_val, cap_data, 32'(m_dat));
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [15:0] v);
    cfg_wr = 1; cfg_wdata = v; tick(); cfg_wr = 0;
  endtask

  function automatic logic [15:0] mk(int e, int a, int s, int w, int ev, int g, int d);
    return 16'((e << 14) | (s << 12) | (a << 9) | (g << 8) | (ev << 6) | (w << 4) | d);
  endfunction

  task automatic pcap(int k);
    cap_evt[k] = 1; tick(); cap_evt = 0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 reset", cfg_rdata, 0);
    wr(16'h3FFF);
    chk("R1 halted write", cfg_rdata, 0);
    mod_run = 1; tick();
    wr(16'h3FFF);
    chk("R3 readback", cfg_rdata, 16'h3FFF);
    wr(16'h8001);
    chk("R2 protected", cfg_rdata, 16'h3FFF);
    wr(16'h1234);
    chk("R2 bit15 reads 0", cfg_rdata[15], 0);
    mod_run = 0; tick(); mod_run = 1;
    chk("R1 cleared on halt", cfg_rdata, 0);

    // internal arming, 16-bit
    wr(mk(1, 0, 0, 1, 2, 0, 0)); tick();
    din_lo = 16'hA55A; pcap(2);
    chk("R4 internal arm valid", cap_valid, 1);
    chk("R7 16-bit data", cap_data, 32'h0000A55A);
    tick();
    chk("R10 one-cycle strobe", cap_valid, 0);
    pcap(1);
    chk("R9 other event ignored", cap_valid, 0);

    wr(mk(1, 0, 0, 0, 2, 0, 0)); din_lo = 16'h1234; pcap(2);
    chk("R7 8-bit data", cap_data, 32'h34);
    wr(mk(1, 0, 0, 2, 2, 0, 0)); din_grp_a = 16'hBEEF; din_grp_b = 16'hCAFE; pcap(2);
    chk("R12 group A", cap_data, 32'hBEEF1234);
    wr(mk(1, 0, 0, 2, 2, 1, 0)); pcap(2);
    chk("R12 group B", cap_data, 32'hCAFE1234);
    wr(mk(1, 0, 0, 3, 2, 1, 0)); din_lo = 16'h5555; pcap(2);
    chk("R8 inhibited no strobe", cap_valid, 0);
    chk("R8 data held", cap_data, 32'hCAFE1234);

    // delay of 3, with a second event during the countdown
    wr(mk(1, 0, 0, 1, 0, 0, 3));
    din_lo = 0; cap_evt[0] = 1; tick(); cap_evt = 0;
    for (int i = 1; i <= 3; i++) begin
      din_lo = 16'(i);
      if (i == 1) cap_evt[0] = 1;
      tick(); cap_evt = 0;
      if (i < 3) chk("R10 not yet sampled", cap_valid, 0);
    end
    chk("R10 delayed strobe", cap_valid, 1);
    chk("R10 sampled at edge e+3", cap_data, 32'h3);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R11 dropped event", cap_valid, 0);
    end

    // external arming
    wr(16'h0000); tick();
    wr(mk(1, 5, 2, 1, 0, 0, 0)); tick(); tick();
    din_lo = 16'h0F0F; pcap(0);
    chk("R5 not armed", cap_valid, 0);
    arm_evt = 3'b001; tick(); arm_evt = 0;
    pcap(0);
    chk("R5 wrong arm input", cap_valid, 0);
    arm_evt = 3'b010; tick(); arm_evt = 0;
    pcap(0);
    chk("R5 armed by arm_evt[1]", cap_valid, 1);
    stop_uf = 3'b001; tick(); stop_uf = 0;
    pcap(0);
    chk("R6 unselected stop ignored", cap_valid, 1);
    stop_uf = 3'b010; tick(); stop_uf = 0;
    pcap(0);
    chk("R6 stopped", cap_valid, 0);
    arm_evt = 3'b010; stop_uf = 3'b010; tick(); arm_evt = 0; stop_uf = 0;
    pcap(0);
    chk("R6 stop wins over arm", cap_valid, 0);
    wr(mk(1, 7, 2, 1, 0, 0, 0));
    arm_uf = 1; tick(); arm_uf = 0;
    din_lo = 16'h7777; pcap(0);
    chk("R5 armed by underflow", cap_data, 32'h7777);
    wr(mk(0, 7, 2, 1, 0, 0, 0)); tick();
    wr(mk(1, 7, 2, 1, 0, 0, 0)); tick();
    pcap(0);
    chk("R6 enable clear ends run", cap_valid, 0);
    repeat (4) tick();
    finish_up();
  end
endmodule